// File: doc/BRIEF.md
# H-Bridge Drive-Mode Signal Router

This block takes a pulse-width signal, a direction bit, their dead-time-separated complements and a mode selection, and produces four active-high gate-control lines for a full bridge: high and low switch of leg A, high and low switch of leg B. A line at 1 means that switch conducts. The block supports three drive schemes. In lock anti-phase both legs switch in opposition. In sign-magnitude one leg switches while the other is held by the direction pair. In asynchronous sign-magnitude a single switch toggles and the other three are held. For the two sign-magnitude schemes, a path select chooses whether off-time current circulates through the high-side or the low-side pair.

The pulse-width source and the dead-time generator sit upstream. The complements `pwm_n_i` and `dir_n_i` arrive already separated from their true signals. The router latches mode and path only where a new pulse-width period begins, so a period is never split between two routings. A final per-leg guard clears both switches of a leg whenever routing would turn on its high and low switch together. The outputs are registered so the gate lines change only on a clock edge. A deasserted enable, the off mode and reset all give the all-open power-down state, in which both motor terminals float.

Top module: `hbr_router`

## Requirements
- R1: While reset is asserted, and in every cycle after a clock edge at which `enable_i` was 0, all four outputs are 0.
- R2: Mode code 2'b00 is power-down: all four outputs are 0 whatever the other inputs are. After reset the held mode is 2'b00 until the first period boundary.
- R3: Mode code 2'b01 (lock anti-phase): high-A and low-B follow `pwm_i`, low-A and high-B follow `pwm_n_i`.
- R4: Mode code 2'b10 (sign-magnitude) with `path_hi_i`=0 (low-side off-time path): high-A=`pwm_i`, low-A=`pwm_n_i`, high-B=`dir_n_i`, low-B=`dir_i`.
- R5: Mode code 2'b10 with `path_hi_i`=1 (high-side off-time path): high-A=`dir_i`, low-A=`dir_n_i`, high-B=`pwm_n_i`, low-B=`pwm_i`.
- R6: Mode code 2'b11 (asynchronous sign-magnitude) with `path_hi_i`=1: for `dir_i`=1, high-A is 1 and low-B follows `pwm_i`; for `dir_i`=0, high-B is 1 and low-A follows `pwm_i`. The other two outputs are 0.
- R7: Mode code 2'b11 with `path_hi_i`=0: for `dir_i`=1, low-B is 1 and high-A follows `pwm_i`; for `dir_i`=0, low-A is 1 and high-B follows `pwm_i`. The other two outputs are 0.
- R8: In mode code 2'b11, `pwm_n_i` and `dir_n_i` have no effect on any output.
- R9: `mode_i` and `path_hi_i` are taken only in a period-boundary cycle, one in which `pwm_i` is 1 and was 0 at the previous clock edge. The new routing applies from that cycle on. In all other cycles the last values taken stay in force.
- R10: If routing would set the high and low output of one leg both to 1, both outputs of that leg are 0 and the other leg is unaffected.
- R11: Outputs are registered: they show the routing of the inputs sampled at the preceding rising clock edge and do not change between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | 1 allows drive; 0 forces power-down |
| pwm_i | input | 1 | Pulse-width signal, 1 during on-time |
| pwm_n_i | input | 1 | Dead-time-separated complement of `pwm_i` |
| dir_i | input | 1 | Direction, 1 forward, 0 reverse |
| dir_n_i | input | 1 | Dead-time-separated complement of `dir_i` |
| mode_i | input | 2 | 00 off, 01 lock anti-phase, 10 sign-magnitude, 11 asynchronous sign-magnitude |
| path_hi_i | input | 1 | Off-time path: 1 high-side, 0 low-side |
| hi_a_o | output | 1 | Leg A high switch control |
| lo_a_o | output | 1 | Leg A low switch control |
| hi_b_o | output | 1 | Leg B high switch control |
| lo_b_o | output | 1 | Leg B low switch control |

## Verification
A mode change latched at a period boundary can coincide with an overlap on one complement pair, for example during a direction change. The routing then comes from the new mode and the overlap guard acts on it in the same cycle. The bench provokes this by raising `pwm_i` while it switches the mode input from lock anti-phase to low-path sign-magnitude with `dir_i` and `dir_n_i` both high. It expects leg A to carry the new sign-magnitude pattern and leg B to be cleared. The old mode would have left leg B's low switch on, so a response based on it is detected.

// File: rtl/hbr_pkg.sv
package hbr_pkg;

    // Drive scheme codes as seen on mode_i
    typedef enum logic [1:0] {
        DRV_OFF  = 2'b00,
        DRV_LOCK = 2'b01,
        DRV_SM   = 2'b10,
        DRV_ASM  = 2'b11
    } drive_mode_e;

    localparam int unsigned NUM_LEGS = 2;
    localparam int unsigned LEG_A    = 0;
    localparam int unsigned LEG_B    = 1;

    // One half-bridge: high and low switch enables
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_t;

    typedef leg_t [NUM_LEGS-1:0] bridge_t;

endpackage

// File: rtl/hbr_period_sampler.sv
module hbr_period_sampler
    import hbr_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        pwm_i,
    input  drive_mode_e mode_i,
    input  logic        path_hi_i,
    output drive_mode_e mode_o,
    output logic        path_hi_o
);

    typedef struct packed {
        logic        pwm_prev;
        drive_mode_e mode;
        logic        path_hi;
    } smp_state_t;

    smp_state_t st_d, st_q;
    logic       boundary;

    always_comb begin
        st_d          = st_q;
        boundary      = pwm_i & ~st_q.pwm_prev;
        st_d.pwm_prev = pwm_i;
        if (boundary) begin
            st_d.mode    = mode_i;
            st_d.path_hi = path_hi_i;
        end
    end

    // The boundary cycle already uses the newly taken selection
    assign mode_o    = st_d.mode;
    assign path_hi_o = st_d.path_hi;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pwm_prev <= 1'b0;
            st_q.mode     <= DRV_OFF;
            st_q.path_hi  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/hbr_route.sv
module hbr_route
    import hbr_pkg::*;
(
    input  drive_mode_e mode_i,
    input  logic        path_hi_i,
    input  logic        pwm_i,
    input  logic        pwm_n_i,
    input  logic        dir_i,
    input  logic        dir_n_i,
    output bridge_t     legs_o
);

    always_comb begin
        legs_o = '0;
        unique case (mode_i)
            DRV_OFF: begin
                legs_o = '0;
            end
            DRV_LOCK: begin
                legs_o[LEG_A].hi = pwm_i;
                legs_o[LEG_A].lo = pwm_n_i;
                legs_o[LEG_B].hi = pwm_n_i;
                legs_o[LEG_B].lo = pwm_i;
            end
            DRV_SM: begin
                if (path_hi_i) begin
                    legs_o[LEG_A].hi = dir_i;
                    legs_o[LEG_A].lo = dir_n_i;
                    legs_o[LEG_B].hi = pwm_n_i;
                    legs_o[LEG_B].lo = pwm_i;
                end else begin
                    legs_o[LEG_A].hi = pwm_i;
                    legs_o[LEG_A].lo = pwm_n_i;
                    legs_o[LEG_B].hi = dir_n_i;
                    legs_o[LEG_B].lo = dir_i;
                end
            end
            DRV_ASM: begin
                // A single switch toggles; the complements are never used
                if (dir_i) begin
                    if (path_hi_i) begin
                        legs_o[LEG_A].hi = 1'b1;
                        legs_o[LEG_B].lo = pwm_i;
                    end else begin
                        legs_o[LEG_B].lo = 1'b1;
                        legs_o[LEG_A].hi = pwm_i;
                    end
                end else begin
                    if (path_hi_i) begin
                        legs_o[LEG_B].hi = 1'b1;
                        legs_o[LEG_A].lo = pwm_i;
                    end else begin
                        legs_o[LEG_A].lo = 1'b1;
                        legs_o[LEG_B].hi = pwm_i;
                    end
                end
            end
            default: legs_o = '0;
        endcase
    end

endmodule

// File: rtl/hbr_guard.sv
module hbr_guard
    import hbr_pkg::*;
#(
    parameter int unsigned LEGS = NUM_LEGS
) (
    input  leg_t [LEGS-1:0] legs_i,
    output leg_t [LEGS-1:0] legs_o
);

    for (genvar g = 0; g < LEGS; g++) begin : g_leg
        logic clash;
        assign clash        = legs_i[g].hi & legs_i[g].lo;
        assign legs_o[g].hi = legs_i[g].hi & ~clash;
        assign legs_o[g].lo = legs_i[g].lo & ~clash;
    end

endmodule

// File: rtl/hbr_router.sv
module hbr_router
    import hbr_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic       pwm_i,
    input  logic       pwm_n_i,
    input  logic       dir_i,
    input  logic       dir_n_i,
    input  logic [1:0] mode_i,
    input  logic       path_hi_i,
    output logic       hi_a_o,
    output logic       lo_a_o,
    output logic       hi_b_o,
    output logic       lo_b_o
);

    typedef struct packed {
        bridge_t gates;
    } out_state_t;

    drive_mode_e mode_eff;
    logic        path_eff;
    bridge_t     routed;
    bridge_t     safe;
    out_state_t  out_d, out_q;

    hbr_period_sampler i_sampler (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pwm_i     (pwm_i),
        .mode_i    (drive_mode_e'(mode_i)),
        .path_hi_i (path_hi_i),
        .mode_o    (mode_eff),
        .path_hi_o (path_eff)
    );

    hbr_route i_route (
        .mode_i    (mode_eff),
        .path_hi_i (path_eff),
        .pwm_i     (pwm_i),
        .pwm_n_i   (pwm_n_i),
        .dir_i     (dir_i),
        .dir_n_i   (dir_n_i),
        .legs_o    (routed)
    );

    hbr_guard #(
        .LEGS (NUM_LEGS)
    ) i_guard (
        .legs_i (routed),
        .legs_o (safe)
    );

    always_comb begin
        out_d = out_q;
        if (enable_i) begin
            out_d.gates = safe;
        end else begin
            out_d.gates = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign hi_a_o = out_q.gates[LEG_A].hi;
    assign lo_a_o = out_q.gates[LEG_A].lo;
    assign hi_b_o = out_q.gates[LEG_B].hi;
    assign lo_b_o = out_q.gates[LEG_B].lo;

endmodule

// File: rtl/hbr_router_chk.sv
module hbr_router_chk
    import hbr_pkg::*;
(
    input logic        clk_i,
    input logic        rst_ni,
    input logic        enable_i,
    input logic        pwm_i,
    input logic        pwm_n_i,
    input drive_mode_e mode_eff,
    input logic        hi_a_o,
    input logic        lo_a_o,
    input logic        hi_b_o,
    input logic        lo_b_o
);

    logic [3:0] outs;
    assign outs = {hi_a_o, lo_a_o, hi_b_o, lo_b_o};

    p_disable_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (outs == 4'b0000));

    p_off_mode_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && mode_eff == DRV_OFF) |=> (outs == 4'b0000));

    p_lock_routing_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && mode_eff == DRV_LOCK && (pwm_i != pwm_n_i)) |=>
        (hi_a_o == $past(pwm_i) && lo_b_o == $past(pwm_i) &&
         lo_a_o == $past(pwm_n_i) && hi_b_o == $past(pwm_n_i)));

    p_async_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && mode_eff == DRV_ASM) |=> ($countones(outs) <= 2));

    p_hold_midperiod_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$rose(pwm_i) |-> (mode_eff == $past(mode_eff)));

    p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(hi_a_o && lo_a_o) && !(hi_b_o && lo_b_o));

endmodule

bind hbr_router hbr_router_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .pwm_i    (pwm_i),
    .pwm_n_i  (pwm_n_i),
    .mode_eff (mode_eff),
    .hi_a_o   (hi_a_o),
    .lo_a_o   (lo_a_o),
    .hi_b_o   (hi_b_o),
    .lo_b_o   (lo_b_o)
);

// File: tb/test_hbr_router.sv
`timescale 1ns/1ps
module test_hbr_router;

    localparam logic [1:0] M_OFF  = 2'b00;
    localparam logic [1:0] M_LOCK = 2'b01;
    localparam logic [1:0] M_SM   = 2'b10;
    localparam logic [1:0] M_ASM  = 2'b11;

    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic       enable_i, pwm_i, pwm_n_i, dir_i, dir_n_i, path_hi_i;
    logic [1:0] mode_i;
    logic       hi_a_o, lo_a_o, hi_b_o, lo_b_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #10 clk_i = ~clk_i;  // 50 MHz

    hbr_router i_hbr_router (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .enable_i  (enable_i),
        .pwm_i     (pwm_i),
        .pwm_n_i   (pwm_n_i),
        .dir_i     (dir_i),
        .dir_n_i   (dir_n_i),
        .mode_i    (mode_i),
        .path_hi_i (path_hi_i),
        .hi_a_o    (hi_a_o),
        .lo_a_o    (lo_a_o),
        .hi_b_o    (hi_b_o),
        .lo_b_o    (lo_b_o)
    );

    // Output order in expectations: {high A, low A, high B, low B}
    task automatic check(input string tag, input logic [3:0] exp);
        logic [3:0] got;
        got = {hi_a_o, lo_a_o, hi_b_o, lo_b_o};
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input logic en, input logic [1:0] md, input logic ph,
                         input logic p, input logic pn, input logic d, input logic dn);
        enable_i  = en;
        mode_i    = md;
        path_hi_i = ph;
        pwm_i     = p;
        pwm_n_i   = pn;
        dir_i     = d;
        dir_n_i   = dn;
    endtask

    // Drive at a falling edge, check at the next falling edge
    task automatic step(input string tag, input logic en, input logic [1:0] md,
                        input logic ph, input logic p, input logic pn,
                        input logic d, input logic dn, input logic [3:0] exp);
        drive(en, md, ph, p, pn, d, dn);
        @(negedge clk_i);
        check(tag, exp);
    endtask

    // One cycle with pwm low so that the next pwm rise is a boundary
    task automatic arm(input logic [1:0] md, input logic ph, input logic d, input logic dn);
        drive(1'b1, md, ph, 1'b0, 1'b1, d, dn);
        @(negedge clk_i);
    endtask

    task automatic t_reset;
        drive(1'b1, M_LOCK, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        rst_ni = 1'b0;
        repeat (3) @(negedge clk_i);
        check("R1 outputs during reset", 4'b0000);
        rst_ni = 1'b1;
        step("R2 held off mode before first boundary", 1'b1, M_LOCK, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000);
    endtask

    task automatic t_lock;
        step("R3 lock on-time", 1'b1, M_LOCK, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
        drive(1'b1, M_LOCK, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
        #2;
        check("R11 no change before clock edge", 4'b1001);
        @(negedge clk_i);
        check("R3 lock off-time", 4'b0110);
        step("R9 mode change ignored mid-period", 1'b1, M_SM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0110);
        step("R9 mode taken at boundary", 1'b1, M_SM, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b1010);
    endtask

    task automatic t_sm_low;
        step("R4 low path reverse off-time", 1'b1, M_SM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0110);
        step("R4 low path forward off-time", 1'b1, M_SM, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0101);
        step("R4 low path forward on-time", 1'b1, M_SM, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
    endtask

    task automatic t_sm_high;
        arm(M_SM, 1'b1, 1'b1, 1'b0);
        step("R5 high path forward on-time", 1'b1, M_SM, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
        step("R5 high path forward off-time", 1'b1, M_SM, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1010);
        step("R9 path change ignored mid-period", 1'b1, M_SM, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0110);
    endtask

    task automatic t_async_high;
        arm(M_ASM, 1'b1, 1'b1, 1'b0);
        step("R6 fwd on-time", 1'b1, M_ASM, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
        step("R8 complements both high ignored", 1'b1, M_ASM, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 4'b1001);
        step("R6 fwd off-time", 1'b1, M_ASM, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'b1000);
        step("R6 rev off-time", 1'b1, M_ASM, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0010);
        step("R6 rev on-time", 1'b1, M_ASM, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0110);
    endtask

    task automatic t_async_low;
        arm(M_ASM, 1'b0, 1'b1, 1'b0);
        step("R7 fwd on-time", 1'b1, M_ASM, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
        step("R7 fwd off-time", 1'b1, M_ASM, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0001);
        step("R8 rev off-time with complements flipped", 1'b1, M_ASM, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0100);
        step("R7 rev on-time", 1'b1, M_ASM, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'b0110);
    endtask

    task automatic t_guard;
        arm(M_LOCK, 1'b0, 1'b1, 1'b0);
        step("R10 lock overlap clears both legs", 1'b1, M_LOCK, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'b0000);
        arm(M_SM, 1'b0, 1'b1, 1'b0);
        step("R10 direction overlap clears leg B only", 1'b1, M_SM, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b1000);
    endtask

    task automatic t_boundary_with_overlap;
        arm(M_LOCK, 1'b0, 1'b1, 1'b0);
        step("R3 lock on-time before switch", 1'b1, M_LOCK, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
        step("R3 lock off-time before switch", 1'b1, M_LOCK, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0110);
        step("R9 R10 boundary switch with overlap", 1'b1, M_SM, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 4'b1000);
    endtask

    task automatic t_enable;
        arm(M_LOCK, 1'b0, 1'b1, 1'b0);
        step("R3 lock before disable", 1'b1, M_LOCK, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
        step("R1 disable forces all open", 1'b0, M_LOCK, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000);
        step("R1 re-enable resumes routing", 1'b1, M_LOCK, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b1001);
    endtask

    task automatic t_off_mode;
        arm(M_OFF, 1'b0, 1'b1, 1'b0);
        step("R2 off mode on-time", 1'b1, M_OFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 4'b0000);
        step("R2 off mode off-time", 1'b1, M_OFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'b0000);
    endtask

    initial begin
        @(negedge clk_i);
        t_reset();
        t_lock();
        t_sm_low();
        t_sm_high();
        t_async_high();
        t_async_low();
        t_guard();
        t_boundary_with_overlap();
        t_enable();
        t_off_mode();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule